// File: doc/BRIEF.md
# Bus-Idle Automatic Power-Down Controller

This block watches the address-latch-enable strobe of a multiplexed microcontroller bus and raises a power-down request when the strobe stays at a programmed idle level for too long. A 4-bit idle counter advances once per tick of a selectable count source. The source is either a dedicated external count clock or the main system clock. When the counter saturates, power-down is asserted. A deeper sleep indication is asserted as well, but only when three mode bits are set together. Any activity on the strobe releases both indications.

Two 8-bit power-mode registers hold the enables, the idle polarity and the count-source choice. Software loads them over a small write port, and both registers are visible on read-back outputs. An active-low chip-select input forces power-down as soon as it is deselected, with no counting. While deselected, the block also drops an input-gating enable so that downstream logic ignores bus address and control lines.

All asynchronous inputs (strobe, chip-select, external count clock) pass through two-flop synchronisers. The external count clock is edge-detected and used as a count enable, not as a clock. All outputs are registered.

Top module: `idle_pd_ctrl`

## Requirements
- R1: After synchronous reset the outputs are as follows: `pd_o`=0, `sleep_o`=0 and `gate_en_o`=1. Both mode registers read 0x00, so the external count clock is the selected source.
- R2: This requirement assumes main-clock counting, auto power-down enabled and the strobe previously at its active level. `ale_i` moves to the idle level just before rising edge 0. `pd_o` stays 0 through rising edge 17 and goes to 1 at rising edge 18, which is 15 count ticks after the synchronised strobe settles.
- R3: Mode register 0 bit 1 selects the idle level of the strobe: 1 means high is idle, 0 means low is idle. The strobe at the other level holds the counter at zero.
- R4: When mode register 0 bit 2 (auto power-down enable) is 0, the idle counter stays at zero and the strobe never raises `pd_o`.
- R5: Mode register 1 bit 0 selects the count source: 0 counts rising edges of `ext_cnt_clk_i`, and 1 counts every `clk` cycle. With source 0 and a quiet `ext_cnt_clk_i`, `pd_o` never rises.
- R6: `sleep_o` is 1 only when all of the following hold: mode register 1 bit 1 (sleep enable) is 1, mode register 0 bit 2 is 1, mode register 0 bit 1 is 1, and the counter has saturated. Whenever `sleep_o` is 1, `pd_o` is also 1.
- R7: After an idle timeout, a change of `ale_i` releases both `pd_o` and `sleep_o`. Both are 0 by the fourth rising edge after the change.
- R8: `cs_n_i` high drives `pd_o`=1 and `gate_en_o`=0 by the third rising edge, whatever the mode bits are. Returning `cs_n_i` low restores `gate_en_o`=1 by the third rising edge.
- R9: A write with `reg_wr_i`=1 stores all 8 bits of `reg_wdata_i`. The target is mode register 0 when `reg_addr_i`=0 and mode register 1 when it is 1. `reg0_o` and `reg1_o` show the stored values from the next cycle.
- R10: The idle counter saturates and does not wrap: `pd_o` stays 1 for as long as the strobe is held idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ale_i | input | 1 | Address-latch-enable strobe from the bus (asynchronous) |
| cs_n_i | input | 1 | Active-low chip select (asynchronous) |
| ext_cnt_clk_i | input | 1 | Dedicated external count clock (asynchronous) |
| reg_wr_i | input | 1 | Mode register write strobe |
| reg_addr_i | input | 1 | Mode register select |
| reg_wdata_i | input | 8 | Mode register write data |
| reg0_o | output | 8 | Read-back of mode register 0 |
| reg1_o | output | 8 | Read-back of mode register 1 |
| pd_o | output | 1 | Power-down request |
| sleep_o | output | 1 | Deep sleep indication |
| gate_en_o | output | 1 | Input-gating enable; 0 blocks bus inputs downstream |

## Verification
Several properties are checked by assertions on every cycle. Sleep never appears without power-down, and sleep only follows a configuration with all three bits set. A disabled auto power-down keeps the counter at zero, a saturated idle counter holds its value, a deselected chip forces power-down and gating on the next cycle, and register writes land in the addressed register. Other behaviour can only be shown by the bench's scenarios: the exact 15-tick timeout latency, the choice between count sources, release on strobe activity, and the full sweep of polarity, enable, sleep and source settings against arithmetically predicted outputs.

// File: rtl/idle_pd_pkg.sv
package idle_pd_pkg;
  localparam int unsigned REG_W         = 8;
  localparam int unsigned R0_IDLE_HI_BIT = 1;
  localparam int unsigned R0_APD_EN_BIT  = 2;
  localparam int unsigned R1_SRC_BIT     = 0;
  localparam int unsigned R1_SLEEP_BIT   = 1;

  typedef struct packed {
    logic sleep_en;
    logic src_main;
    logic apd_en;
    logic idle_high;
  } pm_cfg_t;
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/pm_regs.sv
module pm_regs
  import idle_pd_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] reg0_o,
  output logic [DATA_W-1:0] reg1_o,
  output pm_cfg_t           cfg_o
);
  logic [DATA_W-1:0] r0_q, r1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      r0_q <= '0;
      r1_q <= '0;
    end else if (wr_i) begin
      if (addr_i) r1_q <= wdata_i;
      else        r0_q <= wdata_i;
    end
  end

  assign reg0_o          = r0_q;
  assign reg1_o          = r1_q;
  assign cfg_o.idle_high = r0_q[R0_IDLE_HI_BIT];
  assign cfg_o.apd_en    = r0_q[R0_APD_EN_BIT];
  assign cfg_o.src_main  = r1_q[R1_SRC_BIT];
  assign cfg_o.sleep_en  = r1_q[R1_SLEEP_BIT];

  // R9: addressed register takes the written byte
  assert_wr_reg0_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !addr_i) |=> (reg0_o == $past(wdata_i)));
  assert_wr_reg1_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i) |=> (reg1_o == $past(wdata_i)));
endmodule

// File: rtl/idle_counter.sv
module idle_counter
  import idle_pd_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    tick_i,
  input  logic    strobe_i,
  input  logic    strobe_d_i,
  input  pm_cfg_t cfg_i,
  output logic    sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             clr;

  assign clr = !cfg_i.apd_en
             || (strobe_i != cfg_i.idle_high)
             || (strobe_i != strobe_d_i);

  always_ff @(posedge clk) begin
    if (rst)                              cnt_q <= '0;
    else if (clr)                         cnt_q <= '0;
    else if (tick_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign sat_o = (cnt_q == CNT_MAX);

  // R4: disabled auto power-down keeps the counter empty
  assert_disabled_clears_R4: assert property (@(posedge clk) disable iff (rst)
    !cfg_i.apd_en |=> (cnt_q == '0));
  // R10: saturated counter holds while the strobe stays idle
  assert_saturate_R10: assert property (@(posedge clk) disable iff (rst)
    (sat_o && cfg_i.apd_en && strobe_i == cfg_i.idle_high && strobe_i == strobe_d_i) |=> sat_o);
endmodule

// File: rtl/idle_pd_ctrl.sv
module idle_pd_ctrl
  import idle_pd_pkg::*;
#(
  parameter int unsigned DATA_W      = REG_W,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale_i,
  input  logic              cs_n_i,
  input  logic              ext_cnt_clk_i,
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg0_o,
  output logic [DATA_W-1:0] reg1_o,
  output logic              pd_o,
  output logic              sleep_o,
  output logic              gate_en_o
);
  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0] raw_in, sync_out;
  logic             ale_s, cs_n_s, ext_s;
  logic             ale_d, ext_d;
  logic             ext_tick, tick;
  logic             sat;
  pm_cfg_t          cfg;
  logic             pd_q, sleep_q, gate_q;

  assign raw_in = {ext_cnt_clk_i, cs_n_i, ale_i};

  sync_bank #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_in), .q_o(sync_out)
  );

  assign ale_s  = sync_out[0];
  assign cs_n_s = sync_out[1];
  assign ext_s  = sync_out[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_d <= 1'b0;
      ext_d <= 1'b0;
    end else begin
      ale_d <= ale_s;
      ext_d <= ext_s;
    end
  end

  assign ext_tick = ext_s && !ext_d;
  assign tick     = cfg.src_main ? 1'b1 : ext_tick;

  pm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .reg0_o(reg0_o), .reg1_o(reg1_o), .cfg_o(cfg)
  );

  idle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .strobe_i(ale_s),
    .strobe_d_i(ale_d), .cfg_i(cfg), .sat_o(sat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_q    <= 1'b0;
      sleep_q <= 1'b0;
      gate_q  <= 1'b1;
    end else begin
      pd_q    <= cs_n_s || (cfg.apd_en && sat);
      sleep_q <= cfg.sleep_en && cfg.apd_en && cfg.idle_high && sat;
      gate_q  <= !cs_n_s;
    end
  end

  assign pd_o      = pd_q;
  assign sleep_o   = sleep_q;
  assign gate_en_o = gate_q;

  // R8: deselect forces power-down and closes the input gate
  assert_cs_forces_pd_R8: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (pd_o && !gate_en_o));
  // R6: sleep never without power-down
  assert_sleep_implies_pd_R6: assert property (@(posedge clk) disable iff (rst)
    sleep_o |-> pd_o);
  // R6: sleep follows only a full three-bit configuration
  assert_sleep_cfg_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_o) |-> $past(cfg.sleep_en && cfg.apd_en && cfg.idle_high));
endmodule

// File: tb/tb_idle_pd_ctrl.sv
module tb_idle_pd_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ale = 1'b0, cs_n = 1'b0, ext = 1'b0;
  logic       wr = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] reg0, reg1;
  logic       pd, sleep, gate_en;
  logic       ext_run = 1'b0;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  idle_pd_ctrl dut (
    .clk(clk), .rst(rst), .ale_i(ale), .cs_n_i(cs_n), .ext_cnt_clk_i(ext),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg0_o(reg0), .reg1_o(reg1), .pd_o(pd), .sleep_o(sleep), .gate_en_o(gate_en)
  );

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (ext_run) begin
        ph = ph + 1;
        if (ph % 2 == 0) ext = ~ext;
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wreg(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pd", {7'b0, pd}, 8'h00);
    chk("R1 sleep", {7'b0, sleep}, 8'h00);
    chk("R1 gate", {7'b0, gate_en}, 8'h01);
    chk("R1 reg0", reg0, 8'h00);
    chk("R1 reg1", reg1, 8'h00);

    // R9 write and readback of full bytes
    wreg(1'b0, 8'hA5); chk("R9 reg0", reg0, 8'hA5);
    wreg(1'b1, 8'h5A); chk("R9 reg1", reg1, 8'h5A);
    chk("R9 reg0 kept", reg0, 8'hA5);

    // R2 exact timeout latency, main-clock source, idle high
    wreg(1'b0, 8'h06); wreg(1'b1, 8'h01);
    ale = 1'b0; cyc(8);
    ale = 1'b1;
    cyc(18); chk("R2 before timeout", {7'b0, pd}, 8'h00);
    cyc(1);  chk("R2 at timeout", {7'b0, pd}, 8'h01);
    // R10 saturation: no wrap while idle
    begin
      logic dropped = 1'b0;
      for (int i = 0; i < 40; i++) begin cyc(1); if (!pd) dropped = 1'b1; end
      chk("R10 held", {7'b0, dropped}, 8'h00);
    end

    // R5 external source with quiet count clock never times out
    wreg(1'b1, 8'h00);
    ale = 1'b0; cyc(8); ale = 1'b1; cyc(60);
    chk("R5 quiet ext", {7'b0, pd}, 8'h00);

    // R3 R4 R5 R6 R7 sweep over all mode combinations
    ext_run = 1'b1;
    for (int c = 0; c < 16; c++) begin
      logic src = c[0], pol = c[1], en = c[2], slp = c[3];
      wreg(1'b0, {5'b0, en, pol, 1'b0});
      wreg(1'b1, {6'b0, slp, src});
      ale = ~pol; cyc(8);
      chk("R3 active level no pd", {7'b0, pd}, 8'h00);
      ale = pol; cyc(120);
      chk("R3 R4 R5 pd after idle", {7'b0, pd}, {7'b0, en});
      chk("R6 sleep after idle", {7'b0, sleep}, {7'b0, en & slp & pol});
      ale = ~pol; cyc(4);
      chk("R7 pd released", {7'b0, pd}, 8'h00);
      chk("R7 sleep released", {7'b0, sleep}, 8'h00);
    end
    ext_run = 1'b0;

    // R8 chip select forces power-down with auto power-down disabled
    wreg(1'b0, 8'h00);
    cs_n = 1'b1; cyc(3);
    chk("R8 pd on deselect", {7'b0, pd}, 8'h01);
    chk("R8 gate closed", {7'b0, gate_en}, 8'h00);
    cs_n = 1'b0; cyc(3);
    chk("R8 gate reopened", {7'b0, gate_en}, 8'h01);
    chk("R8 pd released", {7'b0, pd}, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule